// File: doc/BRIEF.md
# Linear Chirp Frequency Ramp Engine

This block produces a linear frequency sweep for a direct digital synthesizer. A frequency accumulator holds the current tuning word. At a programmable interval it adds a signed step word to the tuning word. A phase accumulator adds the tuning word on every clock, and the top bits of that accumulator form the output phase.

The host programs three registers through a simple write port: the start frequency, the signed step and the ramp interval. Writing the start frequency also loads it as the current tuning word. The sweep has no end frequency and continues until the host stops it. The host can stop it with the hold input or with a zero step. It can restart the sweep as a sawtooth with the frequency clear, or cut the output with the phase clear.

An uncontrolled sweep clamps at dc and at Nyquist instead of wrapping.

Top module: `chirp_ramp_engine`

## Requirements
- R1: After reset, ftw_o and phase_o are 0 and all three registers read as 0.
- R2: A write with wr_sel_i = 0 stores wr_data_i as the start frequency F1 and sets ftw_o to it after that clock edge. This takes priority over hold and over stepping. wr_sel_i = 1 writes the step word and wr_sel_i = 2 writes the ramp interval, which is the low 16 bits of wr_data_i.
- R3: With ramp interval N, the tuning word takes one step every N+1 unheld clocks. The interval counter restarts at N on a write to F1 or on a frequency clear. N = 0 steps on every clock.
- R4: The step word is a 48-bit two's complement number. A word with bit 47 set lowers the frequency by its magnitude on each step.
- R5: A step word of zero leaves ftw_o constant while the sweep runs.
- R6: While hold_i is high, ftw_o and the interval counter freeze, and the phase accumulator keeps adding ftw_o on each clock.
- R7: A high clr_freq_i returns ftw_o to F1 at the next edge. It wins over a step and over hold that fall in the same cycle.
- R8: A high clr_phase_i sets the phase accumulator to 0 at the next edge and leaves ftw_o unchanged.
- R9: A step that would take the tuning word below 0 leaves it at 0.
- R10: A step that would take the tuning word above 2^47 (Nyquist) leaves it at 2^47.
- R11: The 48-bit phase accumulator adds ftw_o on every clock. phase_o is its top 14 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 start freq, 1 step word, 2 ramp interval |
| wr_data_i | input | 48 | Write data |
| hold_i | input | 1 | Freeze the sweep |
| clr_freq_i | input | 1 | Return the tuning word to the start frequency |
| clr_phase_i | input | 1 | Zero the phase accumulator |
| ftw_o | output | 48 | Current tuning word |
| phase_o | output | 14 | Output phase, top bits of the phase accumulator |

## Verification
The frequency clear and a ramp step can land in the same cycle. Running with interval 0 puts a step in every cycle, so a clear pulse issued during an unheld sweep always collides with one. The bench judges the result by checking that ftw_o equals F1 and not F1 plus the step. Hold and the phase clear can also coincide: the bench pulses the phase clear while held and checks that the phase then advances by exactly the frozen tuning word per clock.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
  localparam int unsigned FTW_W   = 48;
  localparam int unsigned PH_OUT_W = 14;
  localparam int unsigned RATE_W  = 16;

  typedef enum logic [1:0] {
    SEL_F1    = 2'd0,
    SEL_STEP  = 2'd1,
    SEL_RATE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/chirp_regs.sv
module chirp_regs
  import chirp_pkg::*;
#(
  parameter int unsigned W      = FTW_W,
  parameter int unsigned RATE_BW = RATE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [W-1:0]       wr_data_i,
  output logic [W-1:0]       f1_o,
  output logic [W-1:0]       step_o,
  output logic [RATE_BW-1:0] rate_o,
  output logic               load_f1_o
);
  reg_sel_e sel;
  assign sel       = reg_sel_e'(wr_sel_i);
  assign load_f1_o = wr_en_i && (sel == SEL_F1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f1_o   <= '0;
      step_o <= '0;
      rate_o <= '0;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_F1:   f1_o   <= wr_data_i;
        SEL_STEP: step_o <= wr_data_i;
        SEL_RATE: rate_o <= wr_data_i[RATE_BW-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/chirp_rate_timer.sv
module chirp_rate_timer #(
  parameter int unsigned RATE_BW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATE_BW-1:0] rate_i,
  input  logic               hold_i,
  input  logic               restart_i,
  output logic               step_o
);
  logic [RATE_BW-1:0] cnt_q;

  assign step_o = !hold_i && !restart_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= rate_i;
    else if (!hold_i)    cnt_q <= (cnt_q == '0) ? rate_i : cnt_q - 1'b1;
  end

  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !restart_i) |=> $stable(cnt_q));

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (cnt_q == $past(rate_i)));
endmodule

// File: rtl/chirp_freq_acc.sv
module chirp_freq_acc #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] f1_i,
  input  logic         hold_i,
  input  logic         step_i,
  input  logic [W-1:0] delta_i,
  output logic [W-1:0] ftw_o
);
  localparam logic [W-1:0] NYQ = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ftw_q, ftw_step;
  logic [W:0]   sum;

  // sign-extended add; result is negative only via bit W
  assign sum = {1'b0, ftw_q} + {delta_i[W-1], delta_i};

  always_comb begin
    if (sum[W])                 ftw_step = '0;
    else if (sum[W-1:0] > NYQ)  ftw_step = NYQ;
    else                        ftw_step = sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ftw_q <= '0;
    else if (clr_i)   ftw_q <= f1_i;
    else if (load_i)  ftw_q <= load_val_i;
    else if (step_i)  ftw_q <= ftw_step;
  end

  assign ftw_o = ftw_q;

  // R9 R10
  ftw_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ftw_q <= NYQ);

  // R7
  clr_freq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ftw_q == $past(f1_i)));

  // R6
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clr_i && !load_i) |=> $stable(ftw_q));
endmodule

// File: rtl/chirp_phase_acc.sv
module chirp_phase_acc #(
  parameter int unsigned W     = 48,
  parameter int unsigned OUT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [W-1:0]     ftw_i,
  output logic [OUT_W-1:0] phase_o
);
  logic [W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ph_q <= '0;
    else if (clr_i) ph_q <= '0;
    else            ph_q <= ph_q + ftw_i;
  end

  assign phase_o = ph_q[W-1 -: OUT_W];

  // R8
  clr_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ph_q == '0));

  // R11
  ph_zero_ftw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ftw_i == '0) |=> $stable(ph_q));
endmodule

// File: rtl/chirp_ramp_engine.sv
module chirp_ramp_engine
  import chirp_pkg::*;
#(
  parameter int unsigned W       = FTW_W,
  parameter int unsigned OUT_W   = PH_OUT_W,
  parameter int unsigned RATE_BW = RATE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             hold_i,
  input  logic             clr_freq_i,
  input  logic             clr_phase_i,
  output logic [W-1:0]     ftw_o,
  output logic [OUT_W-1:0] phase_o
);
  logic [W-1:0]       f1, delta;
  logic [RATE_BW-1:0] rate;
  logic               load_f1, step;

  chirp_regs #(.W(W), .RATE_BW(RATE_BW)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .f1_o(f1), .step_o(delta), .rate_o(rate), .load_f1_o(load_f1)
  );

  chirp_rate_timer #(.RATE_BW(RATE_BW)) i_timer (
    .clk_i, .rst_ni, .rate_i(rate), .hold_i,
    .restart_i(load_f1 | clr_freq_i), .step_o(step)
  );

  chirp_freq_acc #(.W(W)) i_facc (
    .clk_i, .rst_ni, .clr_i(clr_freq_i), .load_i(load_f1),
    .load_val_i(wr_data_i), .f1_i(f1), .hold_i, .step_i(step),
    .delta_i(delta), .ftw_o
  );

  chirp_phase_acc #(.W(W), .OUT_W(OUT_W)) i_pacc (
    .clk_i, .rst_ni, .clr_i(clr_phase_i), .ftw_i(ftw_o), .phase_o
  );
endmodule

// File: tb/test_chirp_ramp_engine.sv
module test_chirp_ramp_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [47:0] wr_data = '0;
  logic        hold = 1'b1;
  logic        clr_f = 1'b0;
  logic        clr_p = 1'b0;
  logic [47:0] ftw;
  logic [13:0] phase;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [47:0] NYQ = 48'h8000_0000_0000;

  localparam int NV = 6;
  localparam logic [47:0] V_START [NV] = '{48'd1000, 48'd1000, 48'd1000, 48'd10,
                                          NYQ - 48'd10, 48'd0};
  localparam logic [47:0] V_DELTA [NV] = '{48'd5, -48'sd3, 48'd0, -48'sd4,
                                          48'd7, NYQ - 48'd1};
  localparam int          V_N     [NV] = '{10, 10, 20, 5, 3, 1};
  localparam logic [47:0] V_EXP   [NV] = '{48'd1050, 48'd970, 48'd1000, 48'd0,
                                          NYQ, NYQ - 48'd1};
  localparam string       V_REQ   [NV] = '{"R3", "R4", "R5", "R9", "R10", "R4"};

  chirp_ramp_engine i_chirp_ramp_engine (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .hold_i(hold), .clr_freq_i(clr_f),
    .clr_phase_i(clr_p), .ftw_o(ftw), .phase_o(phase)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [47:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    hold = 1'b0;
    repeat (n) @(negedge clk);
    hold = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ftw", ftw, 48'd0);
    chk("R1 phase", {34'd0, phase}, 48'd0);

    wr(2'd2, 48'd0);
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, V_DELTA[i]);
      wr(2'd0, V_START[i]);
      chk("R2 load", ftw, V_START[i]);
      run(V_N[i]);
      chk(V_REQ[i], ftw, V_EXP[i]);
    end

    // R3 interval 3: step lands every fourth unheld clock
    wr(2'd2, 48'd3);
    wr(2'd1, 48'd1);
    wr(2'd0, 48'd0);
    run(3);
    chk("R3 before step", ftw, 48'd0);
    run(1);
    chk("R3 first step", ftw, 48'd1);
    run(4);
    chk("R3 second step", ftw, 48'd2);

    // R7 clear while a step is due in the same cycle
    wr(2'd2, 48'd0);
    wr(2'd1, 48'd5);
    wr(2'd0, 48'd100);
    run(4);
    chk("R7 pre", ftw, 48'd120);
    hold = 1'b0; clr_f = 1'b1;
    @(negedge clk);
    clr_f = 1'b0; hold = 1'b1;
    chk("R7 clear beats step", ftw, 48'd100);
    run(2);
    chk("R7 resumes", ftw, 48'd110);

    // R6 R8 R11 hold with phase clear
    wr(2'd1, 48'd1000);
    wr(2'd0, 48'h0100_0000_0000);
    clr_p = 1'b1;
    @(negedge clk);
    clr_p = 1'b0;
    chk("R8 phase zero", {34'd0, phase}, 48'd0);
    chk("R8 ftw kept", ftw, 48'h0100_0000_0000);
    repeat (5) @(negedge clk);
    chk("R11 phase", {34'd0, phase}, 48'd320);
    chk("R6 ftw frozen", ftw, 48'h0100_0000_0000);

    // R7 clear while held
    wr(2'd0, 48'd7);
    wr(2'd0, 48'd9);
    clr_f = 1'b1;
    @(negedge clk);
    clr_f = 1'b0;
    chk("R7 clear in hold", ftw, 48'd9);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule